// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block turns high-level flash requests (read, program, sector erase, and addressing-mode changes) into the byte-level command traffic a serial NOR flash expects. A request carries an operation code, a start offset and a byte length. The block breaks the request into bus transactions, inserts the write-enable handshake and the busy polling that program and erase need, and reports a completion status. It never drives the serial clock itself. It talks to a byte-exchange engine: for each byte it presents the byte to send and whether that byte closes the transaction. The engine answers with the byte it received and an error flag.

Program data enters on a byte stream that the block consumes one byte per exchange. Read data leaves on a byte stream with one byte per exchange. Flash page size and capacity are configuration inputs. A mode flag selects 3-byte or 4-byte addresses. The flag is set by an initialization request, which compares the capacity against 16 MiB, or by explicit enter and exit requests.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the block is idle. In that state `busy` is 0, `req_ready` is 1, `addr4` is 0, and `x_req` stays low while the block is idle.
- R2: A read (op 0) sends 0x03, then the address, then dummy 0x00 bytes. Each transaction carries at most RD_MAX data bytes. The offset advances by the bytes read, and every received data byte appears on `rd_data` with `rd_valid`.
- R3: The address follows the opcode with the most significant byte first. When `addr4` is 1 it is four bytes; otherwise it is the low three bytes of the offset.
- R4: A program (op 1) sends 0x02, the address, then bytes taken from the write stream. No transaction crosses a boundary of the effective page, which is the smaller of `cfg_page_size` and WR_MAX.
- R5: An erase (op 2) sends 0x20 plus the address, with no data bytes, once per 4096-byte sector. If the offset or the length is not a multiple of 4096, or the length is 0, the request completes with status 4 and no exchange occurs.
- R6: Each program or erase chunk, and each mode change, is preceded by a write-enable transaction (0x06 alone). That is followed by a status read (0x05, 0x00). If received bit 1 is 0, the request ends with status 2 and nothing further is sent.
- R7: Before every program or erase chunk, and once after the last one, the block repeats the status read until received bit 0 is 0. If POLL_LIMIT cycles pass within one polling phase while bit 0 is still 1, the request ends with status 3.
- R8: Op 4 sends 0xB7 and op 5 sends 0xE9, each after write enable. Op 3 sends 0xB7 if `cfg_capacity` > 0x1000000 and 0xE9 otherwise. `addr4` changes only when that command byte completes without error.
- R9: An exchange that returns `x_err` aborts the request at once with status 1, and no further bytes are sent. Unknown ops (6, 7) complete with status 4.
- R10: A request is accepted only when `req_valid` and `req_ready` are both high. `busy` stays high and `req_ready` stays low from acceptance through the one-cycle `done` pulse. A successful request reports status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 3 | 0 read, 1 program, 2 erase, 3 init, 4 enter 4-byte, 5 exit 4-byte |
| req_offset | input | 32 | Start byte offset |
| req_len | input | 32 | Length in bytes |
| cfg_page_size | input | 32 | Device page size, power of two |
| cfg_capacity | input | 32 | Device capacity in bytes |
| wr_valid | input | 1 | Program byte available |
| wr_ready | output | 1 | Program byte consumed this cycle |
| wr_data | input | 8 | Program byte |
| rd_valid | output | 1 | Read byte valid this cycle |
| rd_data | output | 8 | Read byte |
| x_req | output | 1 | Byte exchange requested |
| x_tx | output | 8 | Byte to send |
| x_last | output | 1 | This byte ends the transaction |
| x_ack | input | 1 | Exchange complete |
| x_rx | input | 8 | Byte received during the exchange |
| x_err | input | 1 | Exchange failed |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 3 | 0 ok, 1 bus error, 2 write-enable error, 3 timeout, 4 rejected |
| addr4 | output | 1 | 4-byte addressing active |

## Verification
The embedded assertions check several properties on every cycle. The exchange port is silent while idle, and a pending byte is held steady until it is acknowledged. Every read chunk stays within RD_MAX, and every program chunk stays inside one effective page. Erase addresses are sector aligned, and the addressing flag moves only after a successful mode command. The bench scenarios cover what the assertions cannot: the exact byte order of whole operations, the poll counts, the abort paths after write-enable failure, bus error and timeout, the silent rejection of misaligned erases, and the hold-off of a second request.

// File: rtl/nor_seq_pkg.sv
// Shared types and constants for the serial NOR command sequencer.
// Assumes 32-bit offsets and lengths throughout.
package nor_seq_pkg;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_INIT   = 3'd3,
        OP_ENTER4 = 3'd4,
        OP_EXIT4  = 3'd5,
        OP_BAD6   = 3'd6,
        OP_BAD7   = 3'd7
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_POLL, S_WREN, S_WELRD, S_PREFIX,
        S_RDATA, S_PDATA, S_MODECMD, S_DONE
    } seq_state_e;

    localparam logic [2:0] ST_OK      = 3'd0;
    localparam logic [2:0] ST_BUS     = 3'd1;
    localparam logic [2:0] ST_WEL     = 3'd2;
    localparam logic [2:0] ST_TIMEOUT = 3'd3;
    localparam logic [2:0] ST_INVAL   = 3'd4;

    localparam logic [7:0] CMD_READ   = 8'h03;
    localparam logic [7:0] CMD_PROG   = 8'h02;
    localparam logic [7:0] CMD_ERASE  = 8'h20;
    localparam logic [7:0] CMD_WREN   = 8'h06;
    localparam logic [7:0] CMD_STATUS = 8'h05;
    localparam logic [7:0] CMD_ENTER4 = 8'hB7;
    localparam logic [7:0] CMD_EXIT4  = 8'hE9;

    localparam logic [31:0] SECTOR_BYTES = 32'd4096;
    localparam logic [31:0] WIDE_CAP     = 32'h0100_0000;

endpackage

// File: rtl/nor_addr_fmt.sv
// Command prefix formatter: yields byte idx of the opcode+address prefix.
// Assumes idx stays below the prefix length (4 narrow, 5 wide).
module nor_addr_fmt (
    input  logic [7:0]  opcode,
    input  logic [31:0] offset,
    input  logic        wide,
    input  logic [2:0]  idx,
    output logic [7:0]  byte_o,
    output logic        final_o
);
    logic [2:0] sel;

    // Pick the prefix byte; narrow mode skips the top address byte.
    always_comb begin
        sel = wide ? idx : idx + 3'd1;
        if (idx == 3'd0) begin
            byte_o = opcode;
        end else begin
            case (sel)
                3'd1:    byte_o = offset[31:24];
                3'd2:    byte_o = offset[23:16];
                3'd3:    byte_o = offset[15:8];
                default: byte_o = offset[7:0];
            endcase
        end
        final_o = wide ? (idx == 3'd4) : (idx == 3'd3);
    end
endmodule

// File: rtl/nor_chunk_calc.sv
// Chunk size calculator: bytes the next transaction may carry.
// Assumes page_size and MAX_WR are powers of two.
module nor_chunk_calc
    import nor_seq_pkg::*;
#(
    parameter int MAX_RD = 16,
    parameter int MAX_WR = 64
) (
    input  op_e         op,
    input  logic [31:0] offset,
    input  logic [31:0] remain,
    input  logic [31:0] page_size,
    output logic [31:0] chunk
);
    localparam logic [31:0] RD_LIM = 32'(MAX_RD);
    localparam logic [31:0] WR_LIM = 32'(MAX_WR);

    logic [31:0] eff_page;
    logic [31:0] room;

    // Clip by read limit, page room, or fixed sector size per operation.
    always_comb begin
        eff_page = (page_size < WR_LIM) ? page_size : WR_LIM;
        room     = eff_page - (offset & (eff_page - 32'd1));
        case (op)
            OP_READ:  chunk = (remain < RD_LIM) ? remain : RD_LIM;
            OP_PROG:  chunk = (remain < room) ? remain : room;
            OP_ERASE: chunk = SECTOR_BYTES;
            default:  chunk = 32'd1;
        endcase
    end
endmodule

// File: rtl/nor_deadline.sv
// Poll deadline counter: counts cycles while run is high, clears otherwise.
// Saturates at LIMIT; expired stays high once reached until run drops.
module nor_deadline #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Count cycles of one polling phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  cnt <= '0;
        else if (cnt != LIM) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LIM);
endmodule

// File: rtl/nor_cmd_seq.sv
// Serial NOR command sequencer top. It splits requests into byte-exchange
// transactions, adds write enable, checks the latch, polls busy with a
// deadline and tracks the address width. Assumes the exchange engine keeps
// each transaction open until a byte flagged last or an error.
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int RD_MAX     = 16,
    parameter int WR_MAX     = 64,
    parameter int POLL_LIMIT = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [2:0]  req_op,
    input  logic [31:0] req_offset,
    input  logic [31:0] req_len,
    input  logic [31:0] cfg_page_size,
    input  logic [31:0] cfg_capacity,
    input  logic        wr_valid,
    output logic        wr_ready,
    input  logic [7:0]  wr_data,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    output logic        x_req,
    output logic [7:0]  x_tx,
    output logic        x_last,
    input  logic        x_ack,
    input  logic [7:0]  x_rx,
    input  logic        x_err,
    output logic        busy,
    output logic        done,
    output logic [2:0]  done_status,
    output logic        addr4
);
    seq_state_e  state;
    op_e         op;
    logic [31:0] off, remain, bidx, chunk;
    logic [2:0]  status;
    logic        enter_sel, xfer, dl_expired, pre_final, mode_op;
    logic [7:0]  pre_byte, pre_opc;

    assign mode_op = (op == OP_INIT) || (op == OP_ENTER4) || (op == OP_EXIT4);

    // Opcode for the prefix of the current data operation.
    always_comb begin
        case (op)
            OP_PROG:  pre_opc = CMD_PROG;
            OP_ERASE: pre_opc = CMD_ERASE;
            default:  pre_opc = CMD_READ;
        endcase
    end

    nor_addr_fmt fmt_i (
        .opcode(pre_opc), .offset(off), .wide(addr4), .idx(bidx[2:0]),
        .byte_o(pre_byte), .final_o(pre_final)
    );

    nor_chunk_calc #(.MAX_RD(RD_MAX), .MAX_WR(WR_MAX)) chunk_i (
        .op(op), .offset(off), .remain(remain), .page_size(cfg_page_size),
        .chunk(chunk)
    );

    nor_deadline #(.LIMIT(POLL_LIMIT)) dl_i (
        .clk(clk), .rst_n(rst_n), .run(state == S_POLL), .expired(dl_expired)
    );

    // Exchange port drive: request, byte and end-of-transaction per state.
    always_comb begin
        x_req  = 1'b0;
        x_tx   = 8'h00;
        x_last = 1'b0;
        case (state)
            S_POLL, S_WELRD: begin
                x_req  = 1'b1;
                x_tx   = (bidx == 32'd0) ? CMD_STATUS : 8'h00;
                x_last = bidx[0];
            end
            S_WREN: begin
                x_req = 1'b1; x_tx = CMD_WREN; x_last = 1'b1;
            end
            S_PREFIX: begin
                x_req  = 1'b1;
                x_tx   = pre_byte;
                x_last = pre_final && (op == OP_ERASE);
            end
            S_RDATA: begin
                x_req  = 1'b1;
                x_last = (bidx == chunk - 32'd1);
            end
            S_PDATA: begin
                x_req  = wr_valid;
                x_tx   = wr_data;
                x_last = (bidx == chunk - 32'd1);
            end
            S_MODECMD: begin
                x_req  = 1'b1;
                x_tx   = enter_sel ? CMD_ENTER4 : CMD_EXIT4;
                x_last = 1'b1;
            end
            default: ;
        endcase
    end

    assign xfer        = x_req && x_ack;
    assign wr_ready    = (state == S_PDATA) && xfer && !x_err;
    assign rd_valid    = (state == S_RDATA) && xfer && !x_err;
    assign rd_data     = x_rx;
    assign busy        = (state != S_IDLE);
    assign req_ready   = (state == S_IDLE);
    assign done        = (state == S_DONE);
    assign done_status = status;

    // Main sequencer: accept, walk the phases, advance offset, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            op        <= OP_READ;
            off       <= '0;
            remain    <= '0;
            bidx      <= '0;
            status    <= ST_OK;
            addr4     <= 1'b0;
            enter_sel <= 1'b0;
        end else if (xfer && x_err) begin
            status <= ST_BUS;
            bidx   <= '0;
            state  <= S_DONE;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    op     <= op_e'(req_op);
                    off    <= req_offset;
                    remain <= req_len;
                    bidx   <= '0;
                    status <= ST_OK;
                    case (op_e'(req_op))
                        OP_READ:  state <= (req_len == 32'd0) ? S_DONE : S_PREFIX;
                        OP_PROG:  state <= (req_len == 32'd0) ? S_DONE : S_POLL;
                        OP_ERASE: begin
                            if (req_offset[11:0] != 12'd0 || req_len[11:0] != 12'd0
                                || req_len == 32'd0) begin
                                status <= ST_INVAL;
                                state  <= S_DONE;
                            end else begin
                                state <= S_POLL;
                            end
                        end
                        OP_INIT:   begin enter_sel <= (cfg_capacity > WIDE_CAP); state <= S_WREN; end
                        OP_ENTER4: begin enter_sel <= 1'b1; state <= S_WREN; end
                        OP_EXIT4:  begin enter_sel <= 1'b0; state <= S_WREN; end
                        default:   begin status <= ST_INVAL; state <= S_DONE; end
                    endcase
                end
                S_POLL: if (xfer) begin
                    if (bidx == 32'd0) begin
                        bidx <= 32'd1;
                    end else begin
                        bidx <= '0;
                        if (x_rx[0]) begin
                            if (dl_expired) begin
                                status <= ST_TIMEOUT;
                                state  <= S_DONE;
                            end
                        end else begin
                            state <= (remain == 32'd0) ? S_DONE : S_WREN;
                        end
                    end
                end
                S_WREN: if (xfer) begin
                    bidx  <= '0;
                    state <= S_WELRD;
                end
                S_WELRD: if (xfer) begin
                    if (bidx == 32'd0) begin
                        bidx <= 32'd1;
                    end else begin
                        bidx <= '0;
                        if (!x_rx[1]) begin
                            status <= ST_WEL;
                            state  <= S_DONE;
                        end else begin
                            state <= mode_op ? S_MODECMD : S_PREFIX;
                        end
                    end
                end
                S_PREFIX: if (xfer) begin
                    if (pre_final) begin
                        bidx <= '0;
                        if (op == OP_ERASE) begin
                            off    <= off + SECTOR_BYTES;
                            remain <= remain - SECTOR_BYTES;
                            state  <= S_POLL;
                        end else begin
                            state <= (op == OP_PROG) ? S_PDATA : S_RDATA;
                        end
                    end else begin
                        bidx <= bidx + 32'd1;
                    end
                end
                S_RDATA, S_PDATA: if (xfer) begin
                    if (bidx == chunk - 32'd1) begin
                        bidx   <= '0;
                        off    <= off + chunk;
                        remain <= remain - chunk;
                        if (state == S_PDATA)      state <= S_POLL;
                        else if (remain == chunk)  state <= S_DONE;
                        else                       state <= S_PREFIX;
                    end else begin
                        bidx <= bidx + 32'd1;
                    end
                end
                S_MODECMD: if (xfer) begin
                    addr4 <= enter_sel;
                    state <= S_DONE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Idle block keeps the exchange port quiet.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !x_req);

    // A pending byte (other than streamed program data) holds until acknowledged.
    assert_byte_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (x_req && !x_ack && state != S_PDATA) |=> (x_req && $stable(x_tx)));

    // Read transactions never exceed the configured read limit.
    assert_read_chunk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RDATA) |-> (chunk != 32'd0 && chunk <= 32'(RD_MAX)));

    // Program transactions stay inside one device page and one write window.
    assert_page_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PDATA) |-> (chunk != 32'd0
            && ((off & (cfg_page_size - 32'd1)) + chunk) <= cfg_page_size
            && ((off & 32'(WR_MAX - 1)) + chunk) <= 32'(WR_MAX)));

    // Erase commands are issued only on sector-aligned offsets.
    assert_erase_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PREFIX && op == OP_ERASE) |-> (off[11:0] == 12'd0));

    // Address width changes only right after a clean mode command byte.
    assert_mode_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr4) |-> $past(x_ack && !x_err
            && (x_tx == CMD_ENTER4 || x_tx == CMD_EXIT4)));

    // An accepted request makes the block busy on the next cycle.
    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy && !req_ready));

endmodule

// File: tb/nor_cmd_seq_tb_top.sv
module nor_cmd_seq_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [2:0]  req_op = 3'd0;
    logic [31:0] req_offset = 32'd0, req_len = 32'd0;
    logic [31:0] cfg_page_size = 32'd16, cfg_capacity = 32'd0;
    logic        wr_valid = 1'b1, wr_ready;
    logic [7:0]  wr_data = 8'h00;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        x_req, x_last;
    logic [7:0]  x_tx;
    logic        x_ack = 1'b0, x_err = 1'b0;
    logic [7:0]  x_rx = 8'h00;
    logic        busy, done, addr4;
    logic [2:0]  done_status;

    nor_cmd_seq #(.RD_MAX(8), .WR_MAX(32), .POLL_LIMIT(200)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_offset(req_offset), .req_len(req_len),
        .cfg_page_size(cfg_page_size), .cfg_capacity(cfg_capacity),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .x_req(x_req), .x_tx(x_tx), .x_last(x_last), .x_ack(x_ack),
        .x_rx(x_rx), .x_err(x_err),
        .busy(busy), .done(done), .done_status(done_status), .addr4(addr4)
    );

    int total = 0, bad = 0, xcount = 0;
    bit finished = 0;
    logic [8:0] expq[$];
    logic [7:0] wq[$], rd_exp[$], rd_got[$];
    bit cmp_on = 1, t_mode4 = 0, busy_forever = 0, wel_fail = 0, err_arm = 0;
    int busy_left = 0;
    logic [7:0] err_tx = 8'h00;
    string cur_req = "R1";

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rbyte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h96;
    endfunction

    // Flash and exchange-engine model, checks each byte against the expected sequence
    int tidx = 0;
    logic [7:0] topc = 8'h00;
    logic [31:0] taddr = 32'd0;
    always @(negedge clk) begin : engine
        logic [7:0] tx, rx;
        logic lst;
        logic [8:0] e;
        int plen;
        if (x_ack) begin
            x_ack = 1'b0; x_err = 1'b0;
        end else if (x_req) begin
            tx = x_tx; lst = x_last; rx = 8'h00;
            plen = t_mode4 ? 5 : 4;
            xcount++;
            if (cmp_on) begin
                if (expq.size() == 0) chk(0, cur_req, "unexpected bus byte", tx, 0);
                else begin
                    e = expq.pop_front();
                    chk({lst, tx} == e, cur_req, "bus byte {last,tx}", {lst, tx}, e);
                end
            end
            if (tidx == 0) begin topc = tx; taddr = 32'd0; end
            if (topc == 8'h05 && tidx == 1) begin
                rx = {6'b0, !wel_fail, (busy_forever || busy_left > 0)};
                if (!busy_forever && busy_left > 0) busy_left--;
            end
            if (topc == 8'h03) begin
                if (tidx >= 1 && tidx < plen) taddr = {taddr[23:0], tx};
                if (tidx >= plen) rx = rbyte(taddr + 32'(tidx - plen));
            end
            x_rx  = rx;
            x_err = err_arm && (tx == err_tx);
            if (x_err) err_arm = 0;
            x_ack = 1'b1;
            #1;
            if (wr_ready && wq.size() > 0) void'(wq.pop_front());
            wr_data = (wq.size() > 0) ? wq[0] : 8'h00;
            if (rd_valid) rd_got.push_back(rd_data);
            tidx = (lst || x_err) ? 0 : tidx + 1;
        end
    end

    task automatic e_byte(input logic [7:0] b, input bit last);
        expq.push_back({last, b});
    endtask
    task automatic e_poll(input int nbusy);
        for (int i = 0; i <= nbusy; i++) begin e_byte(8'h05, 0); e_byte(8'h00, 1); end
    endtask
    task automatic e_wren();
        e_byte(8'h06, 1); e_byte(8'h05, 0); e_byte(8'h00, 1);
    endtask
    task automatic e_prefix(input logic [7:0] opc, input logic [31:0] a, input bit fin);
        e_byte(opc, 0);
        if (t_mode4) e_byte(a[31:24], 0);
        e_byte(a[23:16], 0); e_byte(a[15:8], 0); e_byte(a[7:0], fin);
    endtask
    task automatic e_zero(input int n);
        for (int i = 0; i < n; i++) e_byte(8'h00, i == n - 1);
    endtask
    task automatic e_data(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            wq.push_back(base + 8'(i));
            e_byte(base + 8'(i), i == n - 1);
        end
        wr_data = wq[0];
    endtask
    task automatic e_rd(input logic [31:0] a, input int n);
        for (int i = 0; i < n; i++) rd_exp.push_back(rbyte(a + 32'(i)));
    endtask

    // Issue one request, optionally poke a second one while busy, and check completion
    task automatic run_op(input logic [2:0] op, input logic [31:0] off, input logic [31:0] len,
                          input logic [2:0] exp_st, input bit poke, input string rq);
        int cyc = 0, x0;
        bit hold_ok = 1;
        cur_req = rq;
        x0 = xcount;
        rd_got.delete();
        chk(req_ready == 1'b1, "R10", "ready before request", req_ready, 1);
        req_valid = 1'b1; req_op = op; req_offset = off; req_len = len;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R10", "busy after accept", busy, 1);
        while (!done && cyc < 20000) begin
            if (!busy || req_ready) hold_ok = 0;
            req_valid = poke;
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        chk(hold_ok, "R10", "busy held and ready low until done", hold_ok, 1);
        chk(done == 1'b1 && busy == 1'b1, "R10", "done pulse with busy", {done, busy}, 2'b11);
        chk(done_status == exp_st, rq, "completion status", done_status, exp_st);
        if (cmp_on) chk(expq.size() == 0, rq, "bytes still expected", expq.size(), 0);
        if (exp_st == 3'd4) chk(xcount == x0, "R5", "exchanges on rejected request", xcount - x0, 0);
        chk(rd_got.size() == rd_exp.size(), "R2", "read byte count", rd_got.size(), rd_exp.size());
        for (int i = 0; i < rd_got.size() && i < rd_exp.size(); i++)
            if (rd_got[i] !== rd_exp[i]) chk(0, "R2", "read byte value", rd_got[i], rd_exp[i]);
        rd_exp.delete();
        expq.delete();
        wq.delete();
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R10", "idle after done", {busy, done}, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0 && req_ready == 1 && addr4 == 0 && x_req == 0 && done == 0,
            "R1", "reset state {busy,ready,addr4,xreq}", {busy, req_ready, addr4, x_req}, 4'b0100);

        // R8 init at exactly 16 MiB leaves 3-byte mode
        cfg_capacity = 32'h0100_0000;
        e_wren(); e_byte(8'hE9, 1);
        run_op(3'd3, 0, 0, 3'd0, 0, "R8");
        chk(addr4 == 0, "R8", "addr4 after init 16MiB", addr4, 0);

        // R2 R3 read split into 8-byte chunks, 3-byte addresses
        e_prefix(8'h03, 32'h0012_3456, 0); e_zero(8);
        e_prefix(8'h03, 32'h0012_345E, 0); e_zero(2);
        e_rd(32'h0012_3456, 10);
        run_op(3'd0, 32'h0012_3456, 10, 3'd0, 0, "R2");

        // R4 R7 program across a 16-byte page, two busy polls first
        cfg_page_size = 32'd16; busy_left = 2;
        e_poll(2); e_wren(); e_prefix(8'h02, 32'h0000_000C, 0); e_data(4, 8'h40);
        e_poll(0); e_wren(); e_prefix(8'h02, 32'h0000_0010, 0); e_data(16, 8'h44);
        e_poll(0);
        run_op(3'd1, 32'h0000_000C, 20, 3'd0, 0, "R4");

        // R4 page larger than write window: effective page is 32
        cfg_page_size = 32'd64;
        e_poll(0); e_wren(); e_prefix(8'h02, 32'h0000_0028, 0); e_data(24, 8'h80);
        e_poll(0); e_wren(); e_prefix(8'h02, 32'h0000_0040, 0); e_data(6, 8'h98);
        e_poll(0);
        run_op(3'd1, 32'h0000_0028, 30, 3'd0, 0, "R4");

        // R8 init above 16 MiB enters 4-byte mode
        cfg_capacity = 32'h0200_0000;
        e_wren(); e_byte(8'hB7, 1);
        run_op(3'd3, 0, 0, 3'd0, 0, "R8");
        chk(addr4 == 1, "R8", "addr4 after init 32MiB", addr4, 1);
        t_mode4 = 1;

        // R3 read with 4-byte address, second request held off (R10)
        e_prefix(8'h03, 32'h01AB_CDEF, 0); e_zero(3);
        e_rd(32'h01AB_CDEF, 3);
        run_op(3'd0, 32'h01AB_CDEF, 3, 3'd0, 1, "R3");

        // R5 two-sector erase in 4-byte mode
        e_poll(0); e_wren(); e_prefix(8'h20, 32'h0000_2000, 1);
        e_poll(0); e_wren(); e_prefix(8'h20, 32'h0000_3000, 1);
        e_poll(0);
        run_op(3'd2, 32'h0000_2000, 32'h2000, 3'd0, 0, "R5");

        // R5 rejected erases: misaligned offset, zero size, partial sector
        run_op(3'd2, 32'h0000_2100, 32'h1000, 3'd4, 0, "R5");
        run_op(3'd2, 32'h0000_0000, 32'h0, 3'd4, 0, "R5");
        run_op(3'd2, 32'h0000_0000, 32'h800, 3'd4, 0, "R5");

        // R6 latch not set: program stops after the check
        wel_fail = 1;
        e_poll(0); e_wren();
        run_op(3'd1, 32'h0000_0100, 8, 3'd2, 0, "R6");
        wel_fail = 0;

        // R9 R8 bus error on exit command: mode unchanged
        err_tx = 8'hE9; err_arm = 1;
        e_wren(); e_byte(8'hE9, 1);
        run_op(3'd5, 0, 0, 3'd1, 1, "R9");
        chk(addr4 == 1, "R8", "addr4 kept after failed exit", addr4, 1);

        // R9 bus error on read opcode aborts at once
        err_tx = 8'h03; err_arm = 1;
        e_byte(8'h03, 0);
        run_op(3'd0, 32'h0000_0040, 4, 3'd1, 0, "R9");

        // R7 device stays busy: deadline expires
        cmp_on = 0; busy_forever = 1;
        run_op(3'd2, 32'h0000_0000, 32'h1000, 3'd3, 0, "R7");
        busy_forever = 0; cmp_on = 1;

        // R9 unknown op rejected
        run_op(3'd7, 0, 0, 3'd4, 0, "R9");

        // R8 explicit exit succeeds
        e_wren(); e_byte(8'hE9, 1);
        run_op(3'd5, 0, 0, 3'd0, 0, "R8");
        chk(addr4 == 0, "R8", "addr4 after exit", addr4, 0);
        t_mode4 = 0;

        // R8 explicit enter succeeds
        e_wren(); e_byte(8'hB7, 1);
        run_op(3'd4, 0, 0, 3'd0, 0, "R8");
        chk(addr4 == 1, "R8", "addr4 after enter", addr4, 1);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule